// File: doc/BRIEF.md
# Vector block prefix header parser

This block sits at the front of a vector instruction group and decodes the prefix context carried in its first few 16-bit halfwords. Halfwords arrive one at a time under a valid/ready handshake. The first halfword accepted in a group must carry the all-ones 7-bit header opcode. Its 2-bit mode field then sets how many follow-on halfwords belong to the prefix: none, one offset-plus-short-prefix word, that word plus a long-prefix extension, or both of those plus a second short prefix.

Once the last prefix halfword has been taken, the block pulses a done strobe with all decoded fields valid. When a long extension is present, it also pulses a set-length request that carries the extension. Every halfword accepted in the group, headers and instructions alike, advances an in-group position counter. The decoded prefix becomes active once that counter reaches the programmed activation offset. It then stays active until the block-end input closes the group, which also discards every captured field.

Top module: `vblkHdrParser`

## Requirements
- R1: A halfword offered in the idle state is a header only when bits 6:0 equal 7'b1111111. Otherwise `notHeader` pulses for one cycle in the cycle after acceptance, the block stays idle, no field changes and `halfPos` does not advance.
- R2: On a header, bits 8:7 are reported on `modeOut` and bits 14:12 on `lenField` from the cycle after acceptance. Bits 15, 11:10 and 9 are ignored.
- R3: Mode 2'b00 asserts `hdrDone` for one cycle in the cycle after the header is accepted, with `hasPrefix` = 0. In the other modes `hdrDone` comes with `hasPrefix` = 1.
- R4: In mode 2'b01 the second halfword supplies `actOffset` (bits 15:11) and `shortPfx` (bits 10:0). `hdrDone` follows in the cycle after that halfword is accepted.
- R5: In modes 2'b10 and 2'b11 the third halfword is the long extension on `longExt`, and `hasLong` is set. `setLenReq` pulses once in the cycle after that halfword is accepted and never in the other modes. In mode 2'b10 `hdrDone` pulses in that same cycle.
- R6: In mode 2'b11 the fourth halfword is captured whole on `secondPfx`, `hasSecond` is set, and `hdrDone` pulses in the cycle after it is accepted.
- R7: `halfPos` counts halfwords accepted since the group began, with the header as count 1, and saturates at its maximum. `pfxActive` rises in the cycle after a cycle in which `hasPrefix` = 1 and `halfPos` >= `actOffset`, and never while `hasPrefix` = 0.
- R8: Once set, `pfxActive` holds until `blockEnd`. A cycle with `blockEnd` high returns the block to idle, and on the next cycle every field, flag and `halfPos` read zero.
- R9: `inReady` is low exactly while `blockEnd` is high, and a halfword offered in that cycle is neither counted nor parsed.
- R10: A synchronous `rst` clears every output and the parse state, in the same way as `blockEnd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blockEnd | input | 1 | Closes the current group and discards its context |
| inValid | input | 1 | Halfword offered |
| inHalf | input | 16 | Offered halfword |
| inReady | output | 1 | Halfword can be taken |
| hdrDone | output | 1 | One-cycle strobe, prefix parse finished |
| notHeader | output | 1 | One-cycle strobe, idle halfword lacked the header opcode |
| modeOut | output | 2 | Decoded prefix mode |
| lenField | output | 3 | Header length field |
| hasPrefix | output | 1 | A prefix was decoded for this group |
| actOffset | output | 5 | Activation offset in halfwords |
| shortPfx | output | 11 | First short prefix |
| hasLong | output | 1 | Long extension captured |
| longExt | output | 16 | Long extension, also the set-length value |
| setLenReq | output | 1 | One-cycle set-length request |
| hasSecond | output | 1 | Second short prefix captured |
| secondPfx | output | 16 | Second short-prefix halfword |
| halfPos | output | 8 | In-group halfword count |
| pfxActive | output | 1 | Prefix is in force |

## Verification
The hardest case to reach is the activation boundary. Activation must land exactly one cycle after the count meets the offset, whether the offset falls inside the header itself (offset 0) or far into the instruction body, and it must keep its state across gaps in `inValid`. The stimulus sweeps offsets of 0, 3, 7 and 31 across the three prefix modes and inserts idle cycles between halfwords. A reference model in the bench tracks the count and the activation flag on every clock. A further case drops `blockEnd` on a cycle where a halfword is being offered mid-parse, to show that the halfword is refused and the group is discarded.

// File: rtl/vblk_pkg.sv
package vblk_pkg;
  localparam logic [6:0] HDR_OPC = 7'b1111111;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_SHORT = 2'b01,
    MODE_LONG  = 2'b10,
    MODE_TWIN  = 2'b11
  } pfxMode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SHORT, ST_LONG, ST_SECOND, ST_BODY
  } parseSt_t;

  typedef struct packed {
    logic clearAll;
    logic capHdr;
    logic capShort;
    logic capLong;
    logic capSecond;
    logic markDone;
    logic setPfx;
    logic markNotHdr;
    logic countUp;
  } dpStrobe_t;
endpackage

// File: rtl/vblkHdrCtrl.sv
module vblkHdrCtrl
  import vblk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       blockEnd,
  input  logic       inValid,
  input  logic [6:0] inOpc,
  input  logic [1:0] inMode,
  input  logic [1:0] modeQ,
  output logic       inReady,
  output dpStrobe_t  strobe
);
  parseSt_t stQ, stNxt;
  logic accept;

  assign inReady = !blockEnd;
  assign accept  = inValid && inReady;

  always_comb begin
    stNxt = stQ;
    strobe = '0;
    strobe.clearAll = blockEnd;
    if (accept) begin
      case (stQ)
        ST_IDLE: begin
          if (inOpc == HDR_OPC) begin
            strobe.capHdr  = 1'b1;
            strobe.countUp = 1'b1;
            if (inMode == MODE_NONE) begin
              strobe.markDone = 1'b1;
              stNxt = ST_BODY;
            end else begin
              stNxt = ST_SHORT;
            end
          end else begin
            strobe.markNotHdr = 1'b1;
          end
        end
        ST_SHORT: begin
          strobe.capShort = 1'b1;
          strobe.countUp  = 1'b1;
          if (modeQ == MODE_SHORT) begin
            strobe.markDone = 1'b1;
            strobe.setPfx   = 1'b1;
            stNxt = ST_BODY;
          end else begin
            stNxt = ST_LONG;
          end
        end
        ST_LONG: begin
          strobe.capLong = 1'b1;
          strobe.countUp = 1'b1;
          if (modeQ == MODE_LONG) begin
            strobe.markDone = 1'b1;
            strobe.setPfx   = 1'b1;
            stNxt = ST_BODY;
          end else begin
            stNxt = ST_SECOND;
          end
        end
        ST_SECOND: begin
          strobe.capSecond = 1'b1;
          strobe.countUp   = 1'b1;
          strobe.markDone  = 1'b1;
          strobe.setPfx    = 1'b1;
          stNxt = ST_BODY;
        end
        default: strobe.countUp = 1'b1;
      endcase
    end
    if (blockEnd) stNxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) stQ <= ST_IDLE;
    else     stQ <= stNxt;
  end
endmodule

// File: rtl/vblkHdrData.sv
module vblkHdrData
  import vblk_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int POS_W   = 8,
  parameter int OFF_W   = 5,
  parameter int SHORT_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HALF_W-1:0]  inHalf,
  input  dpStrobe_t          strobe,
  output logic [1:0]         modeQ,
  output logic [2:0]         lenQ,
  output logic               doneQ,
  output logic               notHdrQ,
  output logic               hasPfxQ,
  output logic [OFF_W-1:0]   offQ,
  output logic [SHORT_W-1:0] shortQ,
  output logic               hasLongQ,
  output logic [HALF_W-1:0]  longQ,
  output logic               setLenQ,
  output logic               hasSecondQ,
  output logic [HALF_W-1:0]  secondQ,
  output logic [POS_W-1:0]   posQ,
  output logic               activeQ
);
  localparam int OFF_LSB = HALF_W - OFF_W;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] offWide;
  logic reachNow;

  assign offWide  = POS_W'(offQ);
  assign reachNow = hasPfxQ && (posQ >= offWide);

  always_ff @(posedge clk) begin
    if (rst || strobe.clearAll) begin
      modeQ <= '0; lenQ <= '0; doneQ <= 1'b0; notHdrQ <= 1'b0;
      hasPfxQ <= 1'b0; offQ <= '0; shortQ <= '0; hasLongQ <= 1'b0;
      longQ <= '0; setLenQ <= 1'b0; hasSecondQ <= 1'b0; secondQ <= '0;
      posQ <= '0; activeQ <= 1'b0;
    end else begin
      doneQ   <= strobe.markDone;
      notHdrQ <= strobe.markNotHdr;
      setLenQ <= strobe.capLong;
      if (reachNow) activeQ <= 1'b1;
      if (strobe.countUp && posQ != POS_MAX) posQ <= posQ + 1'b1;
      if (strobe.setPfx) hasPfxQ <= 1'b1;
      if (strobe.capHdr) begin
        modeQ <= inHalf[8:7];
        lenQ  <= inHalf[14:12];
      end
      if (strobe.capShort) begin
        offQ   <= inHalf[HALF_W-1:OFF_LSB];
        shortQ <= inHalf[SHORT_W-1:0];
      end
      if (strobe.capLong) begin
        longQ    <= inHalf;
        hasLongQ <= 1'b1;
      end
      if (strobe.capSecond) begin
        secondQ    <= inHalf;
        hasSecondQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vblkHdrParser.sv
module vblkHdrParser
  import vblk_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        blockEnd,
  input  logic        inValid,
  input  logic [15:0] inHalf,
  output logic        inReady,
  output logic        hdrDone,
  output logic        notHeader,
  output logic [1:0]  modeOut,
  output logic [2:0]  lenField,
  output logic        hasPrefix,
  output logic [4:0]  actOffset,
  output logic [10:0] shortPfx,
  output logic        hasLong,
  output logic [15:0] longExt,
  output logic        setLenReq,
  output logic        hasSecond,
  output logic [15:0] secondPfx,
  output logic [POS_W-1:0] halfPos,
  output logic        pfxActive
);
  dpStrobe_t strobe;

  vblkHdrCtrl u_ctrl (
    .clk(clk), .rst(rst), .blockEnd(blockEnd), .inValid(inValid),
    .inOpc(inHalf[6:0]), .inMode(inHalf[8:7]), .modeQ(modeOut),
    .inReady(inReady), .strobe(strobe)
  );

  vblkHdrData #(.HALF_W(16), .POS_W(POS_W), .OFF_W(5), .SHORT_W(11)) u_data (
    .clk(clk), .rst(rst), .inHalf(inHalf), .strobe(strobe),
    .modeQ(modeOut), .lenQ(lenField), .doneQ(hdrDone), .notHdrQ(notHeader),
    .hasPfxQ(hasPrefix), .offQ(actOffset), .shortQ(shortPfx),
    .hasLongQ(hasLong), .longQ(longExt), .setLenQ(setLenReq),
    .hasSecondQ(hasSecond), .secondQ(secondPfx), .posQ(halfPos),
    .activeQ(pfxActive)
  );
endmodule

// File: rtl/vblkHdrChk.sv
module vblkHdrChk #(
  parameter int POS_W = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        blockEnd,
  input logic        inValid,
  input logic [15:0] inHalf,
  input logic        inReady,
  input logic        hdrDone,
  input logic        notHeader,
  input logic [1:0]  modeOut,
  input logic        hasPrefix,
  input logic        setLenReq,
  input logic [POS_W-1:0] halfPos,
  input logic        pfxActive
);
  p_nothdr_opc_r1: assert property (@(posedge clk) disable iff (rst)
    notHeader |-> $past(inHalf[6:0]) != 7'b1111111);
  p_nothdr_nocount_r1: assert property (@(posedge clk) disable iff (rst)
    notHeader |-> $stable(halfPos));
  p_done_pfx_r3: assert property (@(posedge clk) disable iff (rst)
    hdrDone |-> hasPrefix == (modeOut != 2'b00));
  p_setlen_mode_r5: assert property (@(posedge clk) disable iff (rst)
    setLenReq |-> modeOut[1]);
  p_active_pfx_r7: assert property (@(posedge clk) disable iff (rst)
    pfxActive |-> hasPrefix);
  p_active_hold_r8: assert property (@(posedge clk) disable iff (rst)
    pfxActive && !blockEnd |=> pfxActive);
  p_end_clear_r8: assert property (@(posedge clk) disable iff (rst)
    blockEnd |=> !pfxActive && !hasPrefix && halfPos == '0);
  p_ready_r9: assert property (@(posedge clk) disable iff (rst)
    blockEnd |-> !inReady);
endmodule

bind vblkHdrParser vblkHdrChk #(.POS_W(POS_W)) u_chk (.*);

// File: tb/tb_vblkHdrParser.sv
module tb_vblkHdrParser;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, blockEnd = 1'b0, inValid = 1'b0;
  logic [15:0] inHalf = '0;
  logic inReady, hdrDone, notHeader, hasPrefix, hasLong, setLenReq, hasSecond, pfxActive;
  logic [1:0] modeOut; logic [2:0] lenField; logic [4:0] actOffset;
  logic [10:0] shortPfx; logic [15:0] longExt, secondPfx; logic [7:0] halfPos;

  int total = 0, bad = 0;
  bit started = 0;

  vblkHdrParser dut (.*);

  always #(PERIOD/2) clk = ~clk;

  // reference model state
  int mSt = 0;            // 0 idle,1 short,2 long,3 second,4 body
  int mPos = 0, mOff = 0, mMode = 0, mLen = 0;
  bit mDone = 0, mNot = 0, mPfx = 0, mHasL = 0, mSet = 0, mHasS = 0, mAct = 0;
  int mShort = 0, mLong = 0, mSecond = 0;

  task automatic mClear();
    mSt = 0; mPos = 0; mOff = 0; mMode = 0; mLen = 0; mDone = 0; mNot = 0;
    mPfx = 0; mHasL = 0; mSet = 0; mHasS = 0; mAct = 0;
    mShort = 0; mLong = 0; mSecond = 0;
  endtask

  always @(posedge clk) begin
    started <= 1;
    if (rst || blockEnd) mClear();
    else begin
      bit reach;
      reach = mPfx && (mPos >= mOff);
      mDone = 0; mNot = 0; mSet = 0;
      if (reach) mAct = 1;
      if (inValid) begin
        if (mSt == 0) begin
          if (inHalf[6:0] == 7'h7f) begin
            mMode = inHalf[8:7]; mLen = inHalf[14:12]; mPos = 1;
            if (mMode == 0) begin mDone = 1; mSt = 4; end else mSt = 1;
          end else mNot = 1;
        end else begin
          if (mPos < 255) mPos = mPos + 1;
          case (mSt)
            1: begin
              mOff = inHalf[15:11]; mShort = inHalf[10:0];
              if (mMode == 1) begin mDone = 1; mPfx = 1; mSt = 4; end else mSt = 2;
            end
            2: begin
              mLong = inHalf; mHasL = 1; mSet = 1;
              if (mMode == 2) begin mDone = 1; mPfx = 1; mSt = 4; end else mSt = 3;
            end
            3: begin mSecond = inHalf; mHasS = 1; mDone = 1; mPfx = 1; mSt = 4; end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d t=%0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R1", "notHeader", notHeader, mNot);
    chk("R2", "modeOut", modeOut, mMode);
    chk("R2", "lenField", lenField, mLen);
    chk("R3", "hdrDone", hdrDone, mDone);
    chk("R3", "hasPrefix", hasPrefix, mPfx);
    chk("R4", "actOffset", actOffset, mOff);
    chk("R4", "shortPfx", shortPfx, mShort);
    chk("R5", "longExt", longExt, mLong);
    chk("R5", "hasLong", hasLong, mHasL);
    chk("R5", "setLenReq", setLenReq, mSet);
    chk("R6", "secondPfx", secondPfx, mSecond);
    chk("R6", "hasSecond", hasSecond, mHasS);
    chk("R7", "halfPos", halfPos, mPos);
    chk("R7", "pfxActive", pfxActive, mAct);
    chk("R9", "inReady", inReady, !blockEnd);
  end

  function automatic logic [15:0] hdr(int mode, int len, logic [3:0] junk);
    return {junk[3], len[2:0], junk[2:1], junk[0], mode[1:0], 7'h7f};
  endfunction

  task automatic put(logic [15:0] h);
    @(negedge clk); inValid = 1; inHalf = h;
    @(negedge clk); inValid = 0; inHalf = 16'h5a5a;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic endBlk();
    @(negedge clk); blockEnd = 1;
    @(negedge clk); blockEnd = 0;
  endtask

  task automatic body(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      put(16'h1000 + 16'(i));
      if (gaps && (i % 3 == 1)) idle(2);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    // R10: reset state
    chk("R10", "halfPos after reset", halfPos, 0);
    chk("R10", "pfxActive after reset", pfxActive, 0);
    // R1: non-header, then a valid header still parses
    put(16'h007e);
    put(16'hffbf);
    // R3: mode 00, reserved bits set (R2)
    put(hdr(0, 5, 4'hf));
    body(4, 0);
    endBlk();
    // R4: short prefix, offset 3
    put(hdr(1, 2, 4'h0));
    put({5'd3, 11'h4a5});
    body(5, 1);
    endBlk();
    // R5: long prefix, offset 0 (active immediately)
    put(hdr(2, 7, 4'h5));
    put({5'd0, 11'h7ff});
    put(16'hbeef);
    body(3, 0);
    endBlk();
    // R6: twin prefix, offset 7
    put(hdr(3, 1, 4'ha));
    put({5'd7, 11'h123});
    put(16'h1234);
    put(16'hcafe);
    body(8, 1);
    // R8: active holds over idle time
    idle(5);
    chk("R8", "active held", pfxActive, 1);
    endBlk();
    chk("R8", "cleared by end", hasPrefix, 0);
    // R9: blockEnd with a halfword offered mid-parse
    put(hdr(2, 3, 4'h0));
    @(negedge clk); inValid = 1; inHalf = {5'd1, 11'h055}; blockEnd = 1;
    @(negedge clk); inValid = 0; blockEnd = 0;
    chk("R9", "refused halfword not counted", halfPos, 0);
    // R7: offset 31 with long body
    put(hdr(1, 0, 4'h0));
    put({5'd31, 11'h001});
    body(35, 0);
    // R10: reset mid-block
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R10", "fields after reset", {31'd0, hasPrefix} + halfPos, 0);
    put(hdr(3, 4, 4'h0));
    put({5'd2, 11'h3c3});
    idle(3);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R10", "mode after reset", modeOut, 0);
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule